// File: doc/BRIEF.md
# I2C Write Slave with Program Lockout

This block is the bus-facing front end of a small nonvolatile peripheral that a system controller writes over I2C. It samples the open-drain clock and data lines on a fast system clock and recognises start and stop conditions. After a start it collects one address byte. It answers that byte with an acknowledge only when the byte names this slave: a fixed upper nibble of `0101` followed by four strap inputs, so that up to sixteen such slaves can share one bus. Every data byte that follows a matching address is acknowledged and handed to downstream logic as a one-cycle pulse carrying the byte.

A stop that closes a sequence containing at least one data byte starts an internal programming period of 5 ms, derived from the system clock frequency parameter. For that whole period the slave holds a busy output, leaves the data line released and disregards all bus traffic, including a call to its own address. A repeated start in the middle of a transfer throws away the partial byte and goes back to address reception. Clock stretching and read transfers are not part of this block.

Top module: `i2c_wlock_slave`

## Requirements
- R1: Bus activity before the first START (a falling SDA while SCL is high) is ignored: no acknowledge is driven and rxValid stays low.
- R2: A STOP (a rising SDA while SCL is high) ends the current transaction, and the slave then waits idle for the next START.
- R3: Bits are taken on the rising edge of SCL after a two-stage synchronizer, most significant bit first.
- R4: An address byte equal to {4'b0101, strapAddr} makes sdaDriveLow go to 1 after the falling edge of the 8th SCL pulse and back to 0 after the falling edge of the 9th pulse; sdaDriveLow = 1 means the slave pulls SDA low.
- R5: After any other address byte the slave drives no acknowledge and delivers no data until the next START.
- R6: Each data byte following a matched address is acknowledged like the address and is presented on rxData with rxValid high for exactly one clock.
- R7: A STOP after at least one data byte raises busy for exactly CLK_HZ/200 clock cycles (5 ms); a STOP after an address with no data leaves busy low.
- R8: While busy is high, START, STOP, address and data traffic are all ignored: sdaDriveLow and rxValid stay 0 and the lockout is neither extended nor cut short.
- R9: A repeated START during a transfer restarts address reception from the first bit.
- R10: During and right after reset, sdaDriveLow, rxValid and busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapAddr | input | 4 | Pin-strapped low four address bits |
| sdaDriveLow | output | 1 | 1 = pull SDA low (acknowledge), 0 = release |
| rxData | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle strobe marking a new byte on rxData |
| busy | output | 1 | High for the whole programming lockout |

## Verification
The bench builds the slave with CLK_HZ set to 100000, which shrinks the lockout to 500 clock cycles so that two full lockouts, a complete transfer issued during one of them and its expiry all fit into a short run. The straps are tied to 4'b1010, so the matching address byte is 0x5A and neighbouring values such as 0x5B and 0x51 exercise the mismatch path. A behavioural model fed from the same bus lines is compared against all outputs on every clock, while directed checks look at acknowledge bits, delivered bytes and lockout lengths.

// File: rtl/i2c_wlock_pkg.sv
package i2c_wlock_pkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 4;
  localparam logic [BYTE_W-STRAP_W-1:0] ADDR_NIBBLE = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_IGNORE, ST_LOCK
  } ctrlState_t;

  // control -> datapath
  typedef struct packed {
    logic shiftEn;
    logic startTimer;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic addrMatch;
    logic timerDone;
  } busEvent_t;
endpackage

// File: rtl/i2c_wlock_dp.sv
module i2c_wlock_dp
  import i2c_wlock_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  dpStrobe_t          ctrlStrobe,
  output busEvent_t          busEv,
  output logic [BYTE_W-1:0]  rxData
);
  localparam int BUSY_CYCLES = CLK_HZ / 200;
  localparam int TIMER_W = $clog2(BUSY_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftReg;
  logic [TIMER_W-1:0] timerCnt;

  // synchronizer chains, one per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  assign busEv.sclRise   = sclS & ~sclPrev;
  assign busEv.sclFall   = ~sclS & sclPrev;
  assign busEv.startDet  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign busEv.stopDet   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign busEv.addrMatch = (shiftReg == {ADDR_NIBBLE, strapAddr});
  assign busEv.timerDone = (timerCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctrlStrobe.shiftEn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (ctrlStrobe.startTimer) begin
      timerCnt <= TIMER_W'(BUSY_CYCLES - 1);
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  assign rxData = shiftReg;
endmodule

// File: rtl/i2c_wlock_ctrl.sv
module i2c_wlock_ctrl
  import i2c_wlock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvent_t busEv,
  output dpStrobe_t ctrlStrobe,
  output logic      sdaLow,
  output logic      rxValid,
  output logic      busy
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic writePending;
  logic byteDone;

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign ctrlStrobe.shiftEn = ((state == ST_ADDR) || (state == ST_DATA)) && busEv.sclRise;
  assign ctrlStrobe.startTimer = (state != ST_LOCK) && busEv.stopDet && writePending;
  assign busy = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      writePending <= 1'b0;
      sdaLow       <= 1'b0;
      rxValid      <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (state == ST_LOCK) begin
        if (busEv.timerDone) state <= ST_IDLE;
      end else if (busEv.startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (busEv.stopDet) begin
        state        <= writePending ? ST_LOCK : ST_IDLE;
        writePending <= 1'b0;
        sdaLow       <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (busEv.sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (busEv.sclFall && byteDone) begin
              if (state == ST_DATA) begin
                rxValid      <= 1'b1;
                writePending <= 1'b1;
                sdaLow       <= 1'b1;
                state        <= ST_DATA_ACK;
              end else if (busEv.addrMatch) begin
                sdaLow <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (busEv.sclFall) begin
              sdaLow <= 1'b0;
              bitCnt <= '0;
              state  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wlock_slave.sv
module i2c_wlock_slave
  import i2c_wlock_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [3:0]  strapAddr,
  output logic        sdaDriveLow,
  output logic [7:0]  rxData,
  output logic        rxValid,
  output logic        busy
);
  dpStrobe_t ctrlStrobe;
  busEvent_t busEv;

  i2c_wlock_dp #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .ctrlStrobe(ctrlStrobe),
    .busEv(busEv), .rxData(rxData)
  );

  i2c_wlock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busEv(busEv), .ctrlStrobe(ctrlStrobe),
    .sdaLow(sdaDriveLow), .rxValid(rxValid), .busy(busy)
  );
endmodule

// File: rtl/i2c_wlock_chk.sv
module i2c_wlock_chk #(
  parameter int CLK_HZ = 125_000_000
) (
  input logic clk,
  input logic rstN,
  input logic sdaDriveLow,
  input logic rxValid,
  input logic busy,
  input logic stopSeen
);
  localparam int BUSY_CYCLES = CLK_HZ / 200;
  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else       busyLen <= busy ? busyLen + 1 : 0;
  end

  p_lock_deaf_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!sdaDriveLow && !rxValid));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_valid_acked_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> sdaDriveLow);

  p_lock_from_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  p_lock_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == BUSY_CYCLES));
endmodule

bind i2c_wlock_slave i2c_wlock_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .rxValid(rxValid),
  .busy(busy), .stopSeen(busEv.stopDet)
);

// File: tb/i2c_wlock_slave_tb.sv
`timescale 1ns/1ps
module i2c_wlock_slave_tb;
  localparam int CLK_HZ = 100_000;
  localparam int LOCK_LEN = CLK_HZ / 200;
  localparam logic [3:0] STRAP = 4'b1010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow, rxValid, busy;
  logic [7:0] rxData;
  wire sdaBus = sdaM & ~sdaDriveLow;

  int testsRun = 0, testsFailed = 0;
  logic [7:0] gotBytes[$];
  int lockLens[$];
  int busyRun = 0;

  always #4 clk = ~clk;

  i2c_wlock_slave #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .strapAddr(STRAP), .sdaDriveLow(sdaDriveLow), .rxData(rxData),
    .rxValid(rxValid), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState, mCnt, mPend, mLow, mValid, mShift, mTimer;
  int s0, s1, pS, d0, d1, pD;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mPend = 0; mLow = 0; mValid = 0; mShift = 0; mTimer = 0;
      s0 = 1; s1 = 1; pS = 1; d0 = 1; d1 = 1; pD = 1;
    end else begin
      bit rise, fall, st, sp;
      int nState, nTimer;
      rise = s1 && !pS;
      fall = !s1 && pS;
      st = s1 && pS && pD && !d1;
      sp = s1 && pS && !pD && d1;
      nState = mState;
      nTimer = (mTimer > 0) ? mTimer - 1 : 0;
      mValid = 0;
      if (mState == 6) begin
        if (mTimer == 0) nState = 0;
      end else if (st) begin
        nState = 1; mCnt = 0; mLow = 0;
      end else if (sp) begin
        if (mPend) begin nState = 6; nTimer = LOCK_LEN - 1; end
        else nState = 0;
        mPend = 0; mLow = 0;
      end else if (mState == 1 || mState == 3) begin
        if (rise) begin
          mShift = ((mShift << 1) | d1) & 8'hFF;
          mCnt++;
        end else if (fall && mCnt == 8) begin
          if (mState == 3) begin
            mValid = 1; mPend = 1; mLow = 1; nState = 4;
          end else if (mShift == {4'b0101, STRAP}) begin
            mLow = 1; nState = 2;
          end else nState = 5;
        end
      end else if ((mState == 2 || mState == 4) && fall) begin
        mLow = 0; mCnt = 0; nState = 3;
      end
      mState = nState;
      mTimer = nTimer;
      pS = s1; s1 = s0; s0 = sclM;
      pD = d1; d1 = d0; d0 = sdaBus;
    end
  end

  // per-clock comparison and monitors, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R4/R5/R8 sdaDriveLow vs model", sdaDriveLow, mLow);
      check("R6 rxValid vs model", rxValid, mValid);
      check("R7 busy vs model", busy, mState == 6);
      if (mValid) check("R3 rxData vs model", rxData, mShift);
      if (rxValid) gotBytes.push_back(rxData);
      if (busy) busyRun++;
      else if (busyRun > 0) begin lockLens.push_back(busyRun); busyRun = 0; end
    end
  end

  // ---------------- bus master tasks ----------------
  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; waitClk(4); sclM = 1; waitClk(4);
    sdaM = 0; waitClk(4); sclM = 0; waitClk(4);
  endtask

  task automatic busStop();
    sdaM = 0; waitClk(4); sclM = 1; waitClk(4); sdaM = 1; waitClk(8);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ackSeen);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(4); sclM = 1; waitClk(8); sclM = 0; waitClk(4);
    end
    sdaM = 1; waitClk(4); sclM = 1; waitClk(4);
    ackSeen = !sdaBus;
    waitClk(4); sclM = 0; waitClk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    bit ack;
    waitClk(3);
    check("R10 reset sdaDriveLow", sdaDriveLow, 0);
    check("R10 reset rxValid", rxValid, 0);
    check("R10 reset busy", busy, 0);
    rstN = 1;
    waitClk(4);

    // R1: own address clocked in with no START
    sclM = 0; waitClk(4);
    sendByte(8'h5A, ack);
    check("R1 no ack before START", ack, 0);
    busStop();
    check("R1 no byte before START", gotBytes.size(), 0);

    // R4 R6 R7: matched write of two bytes
    busStart();
    sendByte(8'h5A, ack); check("R4 address ack", ack, 1);
    sendByte(8'hC3, ack); check("R6 data ack 1", ack, 1);
    sendByte(8'h3C, ack); check("R6 data ack 2", ack, 1);
    busStop();
    check("R7 busy after write STOP", busy, 1);

    // R8: traffic during the lockout
    busStart();
    sendByte(8'h5A, ack); check("R8 no ack while busy", ack, 0);
    busStop();
    check("R8 still busy", busy, 1);
    wait (!busy); waitClk(4);

    // R5: wrong address, then own address as data
    busStart();
    sendByte(8'h5B, ack); check("R5 no ack on mismatch", ack, 0);
    sendByte(8'h5A, ack); check("R5 ignored until START", ack, 0);
    busStop(); waitClk(6);
    check("R7 no lock after ignored transfer", busy, 0);

    // R2 R7: address only, STOP returns to idle without lockout
    busStart();
    sendByte(8'h5A, ack); check("R4 address ack again", ack, 1);
    busStop(); waitClk(6);
    check("R2 idle after address-only STOP", busy, 0);

    // R9: repeated START after a mismatch
    busStart();
    sendByte(8'h51, ack); check("R5 mismatch before restart", ack, 0);
    busStart();
    sendByte(8'h5A, ack); check("R9 address ack after repeated START", ack, 1);
    sendByte(8'hA5, ack); check("R9 data ack after repeated START", ack, 1);
    busStop();
    wait (!busy); waitClk(4);

    check("R6 byte count", gotBytes.size(), 3);
    if (gotBytes.size() == 3) begin
      check("R3 byte 0", gotBytes[0], 8'hC3);
      check("R3 byte 1", gotBytes[1], 8'h3C);
      check("R6 byte 2", gotBytes[2], 8'hA5);
    end
    check("R7 lockout count", lockLens.size(), 2);
    foreach (lockLens[i]) check("R7 lockout length", lockLens[i], LOCK_LEN);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule